// File: doc/BRIEF.md
# Precomputation-Gated Magnitude Comparator

This block reports whether an unsigned operand A exceeds an unsigned operand B, with the answer held in a register. The width is a parameter. Each operand is split into its top bit and a lower field of WIDTH-1 bits.

The top bits of both operands are registered every cycle. The lower fields go into registers that load only when the two incoming top bits are equal. When the top bits differ, they alone decide the answer. The lower-field registers then keep their old contents, so the wide lower comparator sees no new input and does not switch.

Each cycle the registered top bits select one of three decision states. DEC_A_WINS means A's top bit is 1 and B's is 0. DEC_B_WINS means A's top bit is 0 and B's is 1. DEC_TIE means the top bits are equal. Any state can move to any other on the next cycle; the only input to that choice is the newly registered pair of top bits. DEC_A_WINS drives the next flag to 1, DEC_B_WINS drives it to 0, and DEC_TIE takes the result of the lower-field comparator.

The result appears two clock edges after the operands are presented. Operands set up before edge k give their flag after edge k+1.

Top module: `pcmp_gt_compare`

## Requirements
- R1: A synchronous reset clears every register. The flag `gt_o` reads 0 after the reset edge.
- R2: The top bits `a_in[WIDTH-1]` and `b_in[WIDTH-1]` are registered at every clock edge outside reset, with no enable.
- R3: When the presented top bits are equal, the lower fields `a_in[WIDTH-2:0]` and `b_in[WIDTH-2:0]` are loaded at that edge.
- R4: When the presented top bits differ, the lower-field registers keep their previous values.
- R5: If the registered top bits are A=1, B=0, the next flag is 1. If they are A=0, B=1, the next flag is 0. The lower fields, including stale ones, have no effect on this.
- R6: If the registered top bits are equal, the next flag is the unsigned lower-field comparison A > B.
- R7: For every input sequence, `gt_o` after edge k+1 equals the full-width unsigned A > B of the operands presented before edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Operand A, unsigned |
| b_in | input | WIDTH | Operand B, unsigned |
| gt_o | output | 1 | Registered flag, 1 when A > B |

## Verification
The assertions watch four things on every cycle:
- the top-bit registers follow the inputs;
- the lower registers load on a top-bit tie and stay frozen otherwise;
- the flag is forced by a top-bit mismatch;
- the flag is 0 after reset.

Some behaviour only the bench scenarios can show:
- that a flag computed against stale lower contents still equals the full-width comparison;
- the two-edge latency over long random sequences;
- how often the lower registers skip a load.

The directed cases cover operands just across the top-bit boundary, equal operands, and lower fields that differ by one.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

    // Decision class taken from the registered top bits
    typedef enum logic [1:0] {
        DEC_TIE    = 2'd0,
        DEC_A_WINS = 2'd1,
        DEC_B_WINS = 2'd2
    } dec_e;

endpackage

// File: rtl/pcmp_precomp.sv
module pcmp_precomp
    import pcmp_pkg::*;
(
    input  logic a_top_i,     // incoming top bit of A
    input  logic b_top_i,     // incoming top bit of B
    input  logic a_top_q_i,   // registered top bit of A
    input  logic b_top_q_i,   // registered top bit of B
    output logic load_en_o,   // lower-field register enable
    output dec_e dec_o
);

    // Lower fields are only worth capturing when the top bits tie
    always_comb begin
        load_en_o = ~(a_top_i ^ b_top_i);
    end

    always_comb begin
        unique case ({a_top_q_i, b_top_q_i})
            2'b10:   dec_o = DEC_A_WINS;
            2'b01:   dec_o = DEC_B_WINS;
            default: dec_o = DEC_TIE;
        endcase
    end

endmodule

// File: rtl/pcmp_lower_cmp.sv
module pcmp_lower_cmp #(
    parameter int LOW_W = 15
) (
    input  logic [LOW_W-1:0] a_lo_i,
    input  logic [LOW_W-1:0] b_lo_i,
    output logic             gt_o
);

    always_comb begin
        gt_o = (a_lo_i > b_lo_i);
    end

endmodule

// File: rtl/pcmp_gt_compare.sv
module pcmp_gt_compare
    import pcmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             gt_o
);

    localparam int LOW_W = WIDTH - 1;
    localparam int TOP   = WIDTH - 1;

    logic             a_top_q, b_top_q;
    logic [LOW_W-1:0] a_lo_q, b_lo_q;
    logic             load_en;
    logic             lo_gt;
    logic             gt_next;
    logic             gt_q;
    dec_e             dec;

    pcmp_precomp u_precomp (
        .a_top_i   (a_in[TOP]),
        .b_top_i   (b_in[TOP]),
        .a_top_q_i (a_top_q),
        .b_top_q_i (b_top_q),
        .load_en_o (load_en),
        .dec_o     (dec)
    );

    pcmp_lower_cmp #(.LOW_W(LOW_W)) u_lower (
        .a_lo_i (a_lo_q),
        .b_lo_i (b_lo_q),
        .gt_o   (lo_gt)
    );

    // Top bits: captured on every edge
    always_ff @(posedge clk) begin
        if (rst) begin
            a_top_q <= 1'b0;
            b_top_q <= 1'b0;
        end else begin
            a_top_q <= a_in[TOP];
            b_top_q <= b_in[TOP];
        end
    end

    // Lower fields: captured only on a top-bit tie
    always_ff @(posedge clk) begin
        if (rst) begin
            a_lo_q <= '0;
            b_lo_q <= '0;
        end else if (load_en) begin
            a_lo_q <= a_in[LOW_W-1:0];
            b_lo_q <= b_in[LOW_W-1:0];
        end
    end

    // Next flag chosen by decision state
    always_comb begin
        unique case (dec)
            DEC_A_WINS: gt_next = 1'b1;
            DEC_B_WINS: gt_next = 1'b0;
            DEC_TIE:    gt_next = lo_gt;
            default:    gt_next = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) gt_q <= 1'b0;
        else     gt_q <= gt_next;
    end

    assign gt_o = gt_q;

    // R1: flag cleared after reset
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !gt_o);

    // R2: top bits follow the inputs every cycle
    assert_top_track_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (a_top_q == $past(a_in[TOP])) && (b_top_q == $past(b_in[TOP])));

    // R3: lower fields loaded on a tie
    assert_lower_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_en)) |->
            (a_lo_q == $past(a_in[LOW_W-1:0])) && (b_lo_q == $past(b_in[LOW_W-1:0])));

    // R4: lower fields frozen on a mismatch
    assert_lower_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_en)) |-> $stable(a_lo_q) && $stable(b_lo_q));

    // R5: top-bit mismatch forces the flag
    assert_a_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (a_top_q && !b_top_q) |=> gt_o);
    assert_b_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (!a_top_q && b_top_q) |=> !gt_o);

    // R6: tie defers to the lower comparison
    assert_tie_lower_R6: assert property (@(posedge clk) disable iff (rst)
        (a_top_q == b_top_q) |=> (gt_o == $past(a_lo_q > b_lo_q)));

endmodule

// File: tb/pcmp_gt_compare_test.sv
module pcmp_gt_compare_test;

    localparam int W = 16;
    localparam logic [W-1:0] TOPBIT = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] LOWMAX = {1'b0, {(W-1){1'b1}}};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         gt_o;

    int tests_run = 0;
    int tests_failed = 0;
    int skipped_loads = 0;
    int total_cycles = 0;
    bit done = 0;

    logic   exp_d1 = 1'b0, exp_d2 = 1'b0;
    string  tag_d1 = "R1", tag_d2 = "R1";

    pcmp_gt_compare #(.WIDTH(W)) uut (
        .clk  (clk),
        .rst  (rst),
        .a_in (a_in),
        .b_in (b_in),
        .gt_o (gt_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic ref_gt(logic [W-1:0] a, logic [W-1:0] b);
        return a > b;
    endfunction

    function automatic string class_tag(logic [W-1:0] a, logic [W-1:0] b);
        if (a[W-1] != b[W-1]) return "R7 R5 R4 R2";
        return "R7 R6 R3 R2";
    endfunction

    task automatic check(string req, logic act, logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: gt_o actual %b expected %b", req, act, exp);
        end
    endtask

    // Check the flag from two calls ago, then present new operands
    task automatic step(logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        check(tag_d2, gt_o, exp_d2);
        a_in = a;
        b_in = b;
        exp_d2 = exp_d1;
        tag_d2 = tag_d1;
        exp_d1 = ref_gt(a, b);
        tag_d1 = class_tag(a, b);
        total_cycles++;
        if (a[W-1] != b[W-1]) skipped_loads++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        a_in = '0;
        b_in = '0;
        repeat (2) @(negedge clk);
        check("R1", gt_o, 1'b0);
        rst = 1'b0;
        exp_d1 = 1'b0;
        exp_d2 = 1'b0;
        tag_d1 = "R1";
        tag_d2 = "R1";
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // Directed corner cases
        step(TOPBIT, LOWMAX);                         // top decides: 1
        step(LOWMAX, TOPBIT);                         // top decides: 0
        step(16'h1234, 16'h1234);                     // equal: 0
        step(16'h0001, 16'h0000);                     // lower by one: 1
        step(16'h8001, 16'h8000);                     // tie high, lower by one: 1
        step(16'h8000, 16'h8001);                     // 0
        step(16'h7FFF, 16'h0000);                     // load lower A>B
        step(16'h0000, 16'hFFFF);                     // stale lower favours A: 0
        step(16'hFFFF, 16'h0000);                     // 1
        step(16'hFFFF, 16'hFFFF);                     // 0
        step(16'h0000, 16'h0000);
        step(16'h0000, 16'h0000);
        step(16'h0000, 16'h0000);

        // Constrained random: tie-heavy and mismatch mixes
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = W'($urandom);
            if (($urandom % 3) == 0) b[W-1] = a[W-1];
            if (($urandom % 8) == 0) b = a;
            step(a, b);
        end

        // Reset in mid stream
        do_reset();
        for (int i = 0; i < 200; i++) step(W'($urandom), W'($urandom));
        step('0, '0);
        step('0, '0);

        $display("[TB] lower registers skipped %0d of %0d loads", skipped_loads, total_cycles);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

endmodule